// File: doc/BRIEF.md
# Binary and Packed-Decimal Add/Subtract ALU

This is a purely combinational 8-bit arithmetic unit for an accumulator-style CPU. It forms add-with-carry and subtract-with-borrow in plain binary or in packed decimal (two BCD digits per byte). The carry input is an inverted borrow for subtraction. In decimal mode each 4-bit digit is corrected separately, using fixed rules that also define the result for operands that are not valid BCD. The N and V flags come from the uncorrected high digit. The Z flag always comes from the pure binary result.

The same datapath also performs compares. The accumulator, X or Y is reduced by the operand, and only the flags are meaningful. The write-enable output tells the surrounding CPU whether the result may be stored. The V flag is copied from the CPU's current V, which comes in as an input.

The unit has no clock. The sequencer presents the operands and the select, and takes the outputs in the same cycle.

Top module: `bcd_alu`

## Requirements
- R1: With `op[2]=0`, `op[0]=0` and `dec_in=0`, the outputs are as follows. `res` = (A+M+C) mod 256. `c_out` is the carry out of bit 7. `n_out` = `res[7]`. `v_out` is set when the signed sum lies outside -128..127. `op[1]` has no effect.
- R2: With `op[2]=0`, `op[0]=1` and `dec_in=0`, `res` = (A-M-(1-C)) mod 256. `c_out`=1 exactly when A-M-(1-C) >= 0. `v_out` is set when the signed difference lies outside -128..127. `n_out` = `res[7]`.
- R3: Decimal add. The low digit is summed with C. If that sum is 16 or more, or its low 4 bits are 0xA or more, those 4 bits get +6. The digit carry becomes (sum >= 16) OR (4 bits + 6 >= 16). The corrected carry feeds the high digit, which follows the same rule, and its carry is `c_out`.
- R4: Decimal subtract. The low digit is formed as a difference with borrow (1-C). When it borrows, its 4 bits get -6 (mod 16), and the digit carry becomes (4 bits < 6). With no borrow, the carry is 1. The corrected carry feeds the high digit, which follows the same rule, and its carry is `c_out`.
- R5: In decimal mode, take the byte made of the uncorrected high digit (4 bits) and the corrected low digit. `n_out` is bit 7 of that byte. `v_out` is the binary overflow rule applied to A, M and that byte.
- R6: `z_out` is 1 exactly when the binary result (A+M+C or A-M-(1-C)) is 0 mod 256, in either mode.
- R7: With `op[2]=1`, a compare is done. `res` = (R-M) mod 256. `c_out` = (R >= M). `z_out` = (R == M). `n_out` = `res[7]`. `v_out` = `v_in`. `c_in` and `dec_in` have no effect.
- R8: The compare source R is X for `op[1:0]=01`, Y for `op[1:0]=10`, and A for `op[1:0]` of 00 or 11.
- R9: `wr_en` is 1 for add and subtract and 0 for every compare.
- R10: Fixed decimal results. 0x0F+0x0F with C=0 gives 0x14. 0x0C+0x0D gives 0x1F. 0x99+0x01 gives 0x00 with C=1 and Z=0. 0x00-0x01 with C=1 gives 0x99 with C=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 8 | Accumulator |
| x_in | input | 8 | X index register (compare source) |
| y_in | input | 8 | Y index register (compare source) |
| m_in | input | 8 | Memory or immediate operand |
| c_in | input | 1 | Carry in (inverted borrow for subtract) |
| dec_in | input | 1 | Packed decimal mode |
| v_in | input | 1 | Current V flag, passed through on compare |
| op | input | 3 | Operation select: see R1, R2, R7, R8 |
| res | output | 8 | Result byte |
| wr_en | output | 1 | Result may be written to a register |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| c_out | output | 1 | Carry flag |
| v_out | output | 1 | Overflow flag |

## Verification
The hardest cases are the decimal operations on digits that are not valid BCD. There, the corrected carry differs from the raw digit carry, and the N, V and Z flags separate from the corrected result. Hitting these cases by hand-picked vectors would leave gaps. The stimulus therefore sweeps every A, M and carry value in both modes, for both add and subtract, against an integer model that works with signed differences rather than complemented sums. Compares are swept over every source value and operand for each register select, while unrelated inputs are varied, so that any leak of carry or decimal mode into a compare shows up.

// File: rtl/bcd_alu.sv
module bcd_alu (
  input  logic [7:0] a_in,
  input  logic [7:0] x_in,
  input  logic [7:0] y_in,
  input  logic [7:0] m_in,
  input  logic       c_in,
  input  logic       dec_in,
  input  logic       v_in,
  input  logic [2:0] op,
  output logic [7:0] res,
  output logic       wr_en,
  output logic       n_out,
  output logic       z_out,
  output logic       c_out,
  output logic       v_out
);

  // carry in bit 4, digit in bits 3:0
  function automatic logic [4:0] fix_digit(input logic [4:0] raw, input logic en, input logic subm);
    logic [4:0] up;
    up = {1'b0, raw[3:0]} + 5'd6;
    if (!en) return raw;
    if (subm) begin
      if (!raw[4]) return {raw[3:0] < 4'd6, raw[3:0] - 4'd6};
      return raw;
    end
    if (raw[4] || raw[3:0] > 4'd9) return {raw[4] | up[4], up[3:0]};
    return raw;
  endfunction

  logic       cmp, sub, dec, cin;
  logic [7:0] lhs, opnd;
  logic [8:0] bin;
  logic [4:0] lo_raw, lo_fix, hi_raw, hi_fix;

  assign cmp  = op[2];
  assign sub  = cmp | op[0];
  assign dec  = dec_in & ~cmp;
  assign cin  = cmp | c_in;
  assign opnd = sub ? ~m_in : m_in;

  always_comb begin
    lhs = a_in;
    if (cmp && op[1:0] == 2'b01) lhs = x_in;
    if (cmp && op[1:0] == 2'b10) lhs = y_in;
  end

  assign bin    = {1'b0, lhs} + {1'b0, opnd} + 9'(cin);
  assign lo_raw = {1'b0, lhs[3:0]} + {1'b0, opnd[3:0]} + 5'(cin);
  assign lo_fix = fix_digit(lo_raw, dec, sub);
  assign hi_raw = {1'b0, lhs[7:4]} + {1'b0, opnd[7:4]} + 5'(lo_fix[4]);
  assign hi_fix = fix_digit(hi_raw, dec, sub);

  assign res   = {hi_fix[3:0], lo_fix[3:0]};
  assign c_out = hi_fix[4];
  assign n_out = hi_raw[3];
  assign z_out = (bin[7:0] == 8'h00);
  assign v_out = cmp ? v_in : ((lhs[7] == opnd[7]) && (hi_raw[3] != lhs[7]));
  assign wr_en = ~cmp;

  always_comb begin
    if (!dec)
      AST_BIN_SUM: assert ({c_out, res} == bin) else $error("binary chain disagrees with full sum"); // R1
    if (cmp)
      AST_CMP_NO_WRITE: assert (!wr_en && v_out == v_in) else $error("compare wrote or changed V"); // R7
    if (cmp)
      AST_CMP_ORDER: assert (c_out == (lhs >= m_in) && z_out == (lhs == m_in)) else $error("compare flags wrong"); // R8
    if (dec && !sub && a_in[3:0] < 4'd10 && a_in[7:4] < 4'd10 && m_in[3:0] < 4'd10 && m_in[7:4] < 4'd10)
      AST_DEC_ADD_BCD: assert (res[3:0] < 4'd10 && res[7:4] < 4'd10) else $error("BCD add left bad digit"); // R3
    if (dec && sub && a_in[3:0] < 4'd10 && a_in[7:4] < 4'd10 && m_in[3:0] < 4'd10 && m_in[7:4] < 4'd10)
      AST_DEC_SUB_BCD: assert (res[3:0] < 4'd10 && res[7:4] < 4'd10) else $error("BCD subtract left bad digit"); // R4
  end

endmodule

// File: tb/tb_bcd_alu.sv
module tb_bcd_alu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [7:0] a_in, x_in, y_in, m_in, res;
  logic       c_in, dec_in, v_in, wr_en, n_out, z_out, c_out, v_out;
  logic [2:0] op;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  bcd_alu dut (
    .a_in(a_in), .x_in(x_in), .y_in(y_in), .m_in(m_in),
    .c_in(c_in), .dec_in(dec_in), .v_in(v_in), .op(op),
    .res(res), .wr_en(wr_en), .n_out(n_out), .z_out(z_out),
    .c_out(c_out), .v_out(v_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: run hung (all requirements), actual cycles %0d expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic int sx(int b);
    return (b > 127) ? b - 256 : b;
  endfunction

  // returns {wr, n, z, c, v, res[7:0]}
  function automatic logic [12:0] model(int a, int x, int y, int m, int c, int d, int v, int o);
    int r, n, z, cy, vv, tot, s, lo, ln, c1, hi, hn, mid, src;
    if (o >= 4) begin
      src = ((o & 3) == 1) ? x : ((o & 3) == 2) ? y : a;
      tot = src - m;
      r = tot & 255;
      return {1'b0, r[7], src == m, tot >= 0, v[0], r[7:0]};
    end
    if ((o & 1) == 0) begin
      tot = a + m + c;
      z = ((tot & 255) == 0);
      if (d == 0) begin
        r = tot & 255; cy = (tot > 255);
        s = sx(a) + sx(m) + c; vv = (s > 127 || s < -128); n = (r >> 7) & 1;
      end else begin
        lo = (a & 15) + (m & 15) + c; c1 = (lo > 15); ln = lo & 15;
        if (c1 != 0 || ln >= 10) begin c1 = c1 | ((ln + 6) >= 16); ln = (ln + 6) & 15; end
        hi = (a >> 4) + (m >> 4) + c1; hn = hi & 15;
        mid = (hn << 4) | ln;
        n = (mid >> 7) & 1; vv = (((a ^ mid) & (m ^ mid) & 128) != 0);
        cy = (hi > 15);
        if (cy != 0 || hn >= 10) begin cy = cy | ((hn + 6) >= 16); hn = (hn + 6) & 15; end
        r = (hn << 4) | ln;
      end
    end else begin
      tot = a - m - (1 - c);
      z = ((tot & 255) == 0);
      if (d == 0) begin
        r = tot & 255; cy = (tot >= 0);
        s = sx(a) - sx(m) - (1 - c); vv = (s > 127 || s < -128); n = (r >> 7) & 1;
      end else begin
        lo = (a & 15) - (m & 15) - (1 - c); c1 = (lo >= 0); ln = lo & 15;
        if (c1 == 0) begin c1 = ((ln - 6) < 0); ln = (ln - 6) & 15; end
        hi = (a >> 4) - (m >> 4) - (1 - c1); hn = hi & 15;
        mid = (hn << 4) | ln;
        n = (mid >> 7) & 1; vv = (((a ^ mid) & (a ^ m) & 128) != 0);
        cy = (hi >= 0);
        if (cy == 0) begin cy = ((hn - 6) < 0); hn = (hn - 6) & 15; end
        r = (hn << 4) | ln;
      end
    end
    return {1'b1, n[0], z[0], cy[0], vv[0], r[7:0]};
  endfunction

  task automatic apply(int a, int x, int y, int m, int c, int d, int v, int o);
    logic [12:0] e;
    logic [12:0] got;
    string tag;
    a_in = a[7:0]; x_in = x[7:0]; y_in = y[7:0]; m_in = m[7:0];
    c_in = c[0]; dec_in = d[0]; v_in = v[0]; op = o[2:0];
    #1;
    e = model(a, x, y, m, c, d, v, o);
    got = {wr_en, n_out, z_out, c_out, v_out, res};
    vectors++;
    if (got !== e) begin
      fails++;
      if (o >= 4) tag = (got[12] !== e[12]) ? "R9" : "R7/R8";
      else if (got[12] !== e[12]) tag = "R9";
      else if (d != 0 && got[11] !== e[11]) tag = "R5";
      else if (d != 0 && got[8] !== e[8]) tag = "R5";
      else if (got[10] !== e[10]) tag = "R6";
      else if (d != 0) tag = (o & 1) ? "R4" : "R3";
      else tag = (o & 1) ? "R2" : "R1";
      $display("FAIL %s a=%h x=%h y=%h m=%h c=%0d d=%0d op=%0d actual {wr,n,z,c,v,res}=%b expected %b",
               tag, a[7:0], x[7:0], y[7:0], m[7:0], c, d, o, got, e);
    end
    #1;
  endtask

  task automatic lit(int a, int m, int c, int o, int er, int ec, int ez, string tag);
    a_in = a[7:0]; x_in = 8'h00; y_in = 8'h00; m_in = m[7:0];
    c_in = c[0]; dec_in = 1'b1; v_in = 1'b0; op = o[2:0];
    #1;
    vectors++;
    if (res !== er[7:0] || c_out !== ec[0] || z_out !== ez[0]) begin
      fails++;
      $display("FAIL %s a=%h m=%h actual res=%h c=%b z=%b expected res=%h c=%0d z=%0d",
               tag, a[7:0], m[7:0], res, c_out, z_out, er[7:0], ec, ez);
    end
    #1;
  endtask

  initial begin
    a_in = 0; x_in = 0; y_in = 0; m_in = 0; c_in = 0; dec_in = 0; v_in = 0; op = 0;
    repeat (3) @(negedge clk);
    vectors++;
    if (res !== 8'h00 || z_out !== 1'b1 || wr_en !== 1'b1 || c_out !== 1'b0) begin
      fails++;
      $display("FAIL R1/R9 reset state actual res=%h z=%b wr=%b c=%b expected 00 1 1 0", res, z_out, wr_en, c_out);
    end
    rst = 1'b0;

    // R10 fixed decimal corner results
    lit(8'h0F, 8'h0F, 0, 0, 8'h14, 0, 0, "R10");
    lit(8'h0C, 8'h0D, 0, 0, 8'h1F, 0, 0, "R10");
    lit(8'h99, 8'h01, 0, 0, 8'h00, 1, 0, "R10");
    lit(8'h00, 8'h01, 1, 1, 8'h99, 0, 0, "R10");

    // R1..R6, R9: every A, M, C in both modes for add and subtract; op[1] toggled
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 2; c++)
          for (int a = 0; a < 256; a++)
            for (int m = 0; m < 256; m++)
              apply(a, 8'h5A, 8'hA5, m, c, d, m & 1, s | ((a & 1) << 1));

    // R7, R8: compares over every source and operand, unrelated inputs varied
    for (int r = 0; r < 256; r++)
      for (int m = 0; m < 256; m++) begin
        apply(r, r ^ 8'hFF, m, m, m & 1, (r >> 1) & 1, r & 1, 4);
        apply(m ^ 8'h3C, r, r ^ 8'h81, m, r & 1, m & 1, (m >> 2) & 1, 5);
        apply(r ^ 8'h18, m, r, m, (m >> 1) & 1, r & 1, m & 1, 6);
      end
    for (int r = 0; r < 256; r += 17)
      for (int m = 0; m < 256; m++)
        apply(r, m, m ^ 8'hFF, m, m & 1, 1, (r >> 3) & 1, 7);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule